// File: doc/BRIEF.md
# Sixteen-bit Processing-Element ALU

This block is the arithmetic unit inside one processing element of a coarse-grained reconfigurable array. Each cycle it receives an operation code, an immediate with a presence flag, a flag that asks for the result to be kept, and the contents of two operand registers. From these it forms a 16-bit value that wraps on overflow. The value leaves the block zero-extended onto a 64-bit combinational output.

When the keep flag is set, the same 16-bit value is captured in a result register on the next rising clock edge. The operations cover wrapping arithmetic, shifts, bitwise logic, sign-driven selection, conditional merge and signed or equality compares that yield a 0/1 flag. Neighbouring logic in the element decodes the operation code and routes the operands.

Top module: `pe_alu_unit`

## Requirements
- R1: The first operand is always `opReg1`. The second operand is `immVal` when `immValid` is 1, and `opReg2` otherwise.
- R2: `aluOut` carries the 16-bit result in bits 15:0, and bits 63:16 are always zero. ADD (code 0), SUB (code 1) and MULT (code 2) keep only the low 16 bits of the exact result.
- R3: On a rising edge with `updateRes`=1, `resReg` takes the value of `aluOut[15:0]`. With `updateRes`=0, `resReg` keeps its value.
- R4: DIV (code 3) gives the unsigned 16-bit quotient op1/op2. A zero divisor gives 0xFFFF.
- R5: LS (code 4) and RS (code 5) are logical shifts and ARS (code 6) is a sign-filling right shift. All three stay within 16 bits, and the shift count is op2 bits 3:0.
- R6: AND (code 7), OR (code 8) and XOR (code 9) are bitwise over 16 bits.
- R7: SEL (code 10) outputs `immVal` when `updateRes`=1. Otherwise it outputs op1 if op1 bit 15 is 1, else op2 if op2 bit 15 is 1, else 0.
- R8: CMERGE (code 11) outputs `immVal` when `immValid`=1, and op1 otherwise.
- R9: CMP (code 12) gives 1 when op1 equals op2. CLT (code 13) gives 1 when op1 < op2 and CGT (code 14) gives 1 when op1 > op2, both as signed 16-bit values. Each gives 0 when its condition is false.
- R10: The unused code 15 yields a result of 0.
- R11: While `rstN` is 0 (asynchronous, active low), `resReg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Operation code |
| immVal | input | 16 | Immediate value |
| immValid | input | 1 | Immediate present |
| updateRes | input | 1 | Capture result into `resReg` |
| opReg1 | input | 16 | First operand register |
| opReg2 | input | 16 | Second operand register |
| aluOut | output | 64 | Zero-extended combinational result |
| resReg | output | 16 | Result register |

## Verification
The bench builds the block with its default widths, a 16-bit datapath and a 64-bit output. At these widths the sign-bit boundary values 0x8000 and 0xFFFF can be reached directly. So can wrap-around in addition, subtraction and multiplication, and shift counts whose upper bits must be masked. The bench mixes register-sourced and immediate-sourced second operands, and it interleaves cycles that keep the result with cycles that do not.

// File: rtl/pe_alu_pkg.sv
package pe_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MULT   = 4'd2,
    OP_DIV    = 4'd3,
    OP_LS     = 4'd4,
    OP_RS     = 4'd5,
    OP_ARS    = 4'd6,
    OP_AND    = 4'd7,
    OP_OR     = 4'd8,
    OP_XOR    = 4'd9,
    OP_SEL    = 4'd10,
    OP_CMERGE = 4'd11,
    OP_CMP    = 4'd12,
    OP_CLT    = 4'd13,
    OP_CGT    = 4'd14,
    OP_RSVD   = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    U_ARITH = 3'd0,
    U_SHIFT = 3'd1,
    U_LOGIC = 3'd2,
    U_PICK  = 3'd3,
    U_CMP   = 3'd4,
    U_NONE  = 3'd5
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    unit_e      unit;
    logic [1:0] sub;      // operation within the unit
    logic       op2Imm;   // second operand from immediate
    logic       pickImm;  // SEL/CMERGE forced to immediate
    logic       loadRes;  // capture into result register
  } alu_ctrl_t;

endpackage

// File: rtl/pe_alu_ctrl.sv
module pe_alu_ctrl
  import pe_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       immValid,
  input  logic       updateRes,
  output alu_ctrl_t  ctrl
);

  alu_op_e opEnum;
  assign opEnum = alu_op_e'(opCode);

  always_comb begin
    ctrl.unit    = U_NONE;
    ctrl.sub     = 2'd0;
    ctrl.op2Imm  = immValid;
    ctrl.pickImm = 1'b0;
    ctrl.loadRes = updateRes;
    unique case (opEnum)
      OP_ADD:    begin ctrl.unit = U_ARITH; ctrl.sub = 2'd0; end
      OP_SUB:    begin ctrl.unit = U_ARITH; ctrl.sub = 2'd1; end
      OP_MULT:   begin ctrl.unit = U_ARITH; ctrl.sub = 2'd2; end
      OP_DIV:    begin ctrl.unit = U_ARITH; ctrl.sub = 2'd3; end
      OP_LS:     begin ctrl.unit = U_SHIFT; ctrl.sub = 2'd0; end
      OP_RS:     begin ctrl.unit = U_SHIFT; ctrl.sub = 2'd1; end
      OP_ARS:    begin ctrl.unit = U_SHIFT; ctrl.sub = 2'd2; end
      OP_AND:    begin ctrl.unit = U_LOGIC; ctrl.sub = 2'd0; end
      OP_OR:     begin ctrl.unit = U_LOGIC; ctrl.sub = 2'd1; end
      OP_XOR:    begin ctrl.unit = U_LOGIC; ctrl.sub = 2'd2; end
      OP_SEL:    begin ctrl.unit = U_PICK;  ctrl.sub = 2'd0; ctrl.pickImm = updateRes; end
      OP_CMERGE: begin ctrl.unit = U_PICK;  ctrl.sub = 2'd1; ctrl.pickImm = immValid; end
      OP_CMP:    begin ctrl.unit = U_CMP;   ctrl.sub = 2'd0; end
      OP_CLT:    begin ctrl.unit = U_CMP;   ctrl.sub = 2'd1; end
      OP_CGT:    begin ctrl.unit = U_CMP;   ctrl.sub = 2'd2; end
      default:   begin ctrl.unit = U_NONE;  ctrl.sub = 2'd0; end
    endcase
  end

endmodule

// File: rtl/pe_alu_datapath.sv
module pe_alu_datapath
  import pe_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] immVal,
  input  logic [DATA_W-1:0] opRegB,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W = $clog2(DATA_W);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] opB;
  logic [SH_W-1:0]   shAmt;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] arithRes, shiftRes, logicRes, pickRes, cmpRes;
  logic signed [DATA_W-1:0] arsRes;

  assign opB    = ctrl.op2Imm ? immVal : opRegB;
  assign shAmt  = opB[SH_W-1:0];
  assign prod   = PROD_W'(opA) * PROD_W'(opB);
  assign arsRes = $signed(opA) >>> shAmt;

  always_comb begin
    unique case (ctrl.sub)
      2'd0:    arithRes = opA + opB;
      2'd1:    arithRes = opA - opB;
      2'd2:    arithRes = prod[DATA_W-1:0];
      default: arithRes = (opB == '0) ? '1 : (opA / opB);
    endcase
  end

  always_comb begin
    unique case (ctrl.sub)
      2'd0:    shiftRes = opA << shAmt;
      2'd1:    shiftRes = opA >> shAmt;
      default: shiftRes = arsRes;
    endcase
  end

  always_comb begin
    unique case (ctrl.sub)
      2'd0:    logicRes = opA & opB;
      2'd1:    logicRes = opA | opB;
      default: logicRes = opA ^ opB;
    endcase
  end

  always_comb begin
    if (ctrl.pickImm)           pickRes = immVal;
    else if (ctrl.sub == 2'd1)  pickRes = opA;
    else if (opA[DATA_W-1])     pickRes = opA;
    else if (opB[DATA_W-1])     pickRes = opB;
    else                        pickRes = '0;
  end

  always_comb begin
    cmpRes = '0;
    unique case (ctrl.sub)
      2'd0:    cmpRes[0] = (opA == opB);
      2'd1:    cmpRes[0] = ($signed(opA) < $signed(opB));
      default: cmpRes[0] = ($signed(opA) > $signed(opB));
    endcase
  end

  always_comb begin
    unique case (ctrl.unit)
      U_ARITH: result = arithRes;
      U_SHIFT: result = shiftRes;
      U_LOGIC: result = logicRes;
      U_PICK:  result = pickRes;
      U_CMP:   result = cmpRes;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/pe_alu_unit.sv
module pe_alu_unit
  import pe_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] immVal,
  input  logic              immValid,
  input  logic              updateRes,
  input  logic [DATA_W-1:0] opReg1,
  input  logic [DATA_W-1:0] opReg2,
  output logic [OUT_W-1:0]  aluOut,
  output logic [DATA_W-1:0] resReg
);

  localparam int PAD_W = OUT_W - DATA_W;

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] result;

  pe_alu_ctrl u_ctrl (
    .opCode    (opCode),
    .immValid  (immValid),
    .updateRes (updateRes),
    .ctrl      (ctrl)
  );

  pe_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl   (ctrl),
    .opA    (opReg1),
    .immVal (immVal),
    .opRegB (opReg2),
    .result (result)
  );

  assign aluOut = {{PAD_W{1'b0}}, result};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resReg <= '0;
    else if (ctrl.loadRes) resReg <= result;
  end

endmodule

// File: rtl/pe_alu_chk.sv
module pe_alu_chk #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] immVal,
  input logic              immValid,
  input logic              updateRes,
  input logic [DATA_W-1:0] opReg1,
  input logic [DATA_W-1:0] opReg2,
  input logic [OUT_W-1:0]  aluOut,
  input logic [DATA_W-1:0] resReg
);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    aluOut[OUT_W-1:DATA_W] == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    updateRes |=> resReg == $past(aluOut[DATA_W-1:0]));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !updateRes |=> $stable(resReg));

  a_r4_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd3 && !immValid && opReg2 == '0) |-> aluOut[DATA_W-1:0] == '1);

  a_r8_merge_imm: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd11 && immValid) |-> aluOut[DATA_W-1:0] == immVal);

  a_r7_sel_imm: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd10 && updateRes) |-> aluOut[DATA_W-1:0] == immVal);

  a_r9_flag_only: assert property (@(posedge clk) disable iff (!rstN)
    (opCode >= 4'd12 && opCode <= 4'd14) |-> aluOut[DATA_W-1:1] == '0);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd15) |-> aluOut == '0);

endmodule

bind pe_alu_unit pe_alu_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opCode    (opCode),
  .immVal    (immVal),
  .immValid  (immValid),
  .updateRes (updateRes),
  .opReg1    (opReg1),
  .opReg2    (opReg2),
  .aluOut    (aluOut),
  .resReg    (resReg)
);

// File: tb/sim_pe_alu_unit.sv
module sim_pe_alu_unit;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [3:0]  opCode = '0;
  logic [15:0] immVal = '0;
  logic        immValid = 1'b0;
  logic        updateRes = 1'b0;
  logic [15:0] opReg1 = '0;
  logic [15:0] opReg2 = '0;
  logic [63:0] aluOut;
  logic [15:0] resReg;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [15:0] expRes = '0;

  typedef struct {
    int          kind;   // 0: aluOut, 1: resReg
    logic [63:0] exp;
    int          req;
  } item_t;

  item_t sbQ[$];
  event  sbEv;

  always #(PERIOD/2) clk = ~clk;

  pe_alu_unit u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .immVal(immVal),
    .immValid(immValid), .updateRes(updateRes), .opReg1(opReg1),
    .opReg2(opReg2), .aluOut(aluOut), .resReg(resReg)
  );

  // reference from the requirement text
  function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] imm,
                                        input logic iv, input logic upd,
                                        input logic [15:0] a, input logic [15:0] rb);
    logic [15:0] b;
    logic [31:0] p;
    b = iv ? imm : rb;
    p = {16'd0, a} * {16'd0, b};
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return p[15:0];
      4'd3:  return (b == 0) ? 16'hFFFF : a / b;
      4'd4:  return a << b[3:0];
      4'd5:  return a >> b[3:0];
      4'd6:  return 16'($signed(a) >>> b[3:0]);
      4'd7:  return a & b;
      4'd8:  return a | b;
      4'd9:  return a ^ b;
      4'd10: return upd ? imm : (a[15] ? a : (b[15] ? b : 16'd0));
      4'd11: return iv ? imm : a;
      4'd12: return {15'd0, a == b};
      4'd13: return {15'd0, $signed(a) < $signed(b)};
      4'd14: return {15'd0, $signed(a) > $signed(b)};
      default: return 16'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [15:0] imm, input logic iv,
                       input logic upd, input logic [15:0] a, input logic [15:0] b,
                       input int req);
    logic [15:0] e;
    item_t it;
    @(negedge clk);
    opCode = op; immVal = imm; immValid = iv; updateRes = upd; opReg1 = a; opReg2 = b;
    e = model(op, imm, iv, upd, a, b);
    #1;
    it.kind = 0; it.exp = {48'd0, e}; it.req = req;
    sbQ.push_back(it); ->sbEv;
    @(posedge clk); #1;
    if (upd) expRes = e;
    it.kind = 1; it.exp = {48'd0, expRes}; it.req = (upd || req != 3) ? req : 3;
    sbQ.push_back(it); ->sbEv;
  endtask

  // monitor
  initial begin
    forever begin
      @(sbEv);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = sbQ.pop_front();
        act = (it.kind == 0) ? aluOut : {48'd0, resReg};
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL R%0d %s actual=%h expected=%h", it.req,
                   (it.kind == 0) ? "aluOut" : "resReg", act, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    nChecks++; // R11 reset value
    if (resReg !== 16'd0) begin
      nFails++;
      $display("FAIL R11 resReg actual=%h expected=0000", resReg);
    end
    @(negedge clk) rstN = 1'b1;

    // R2 wrap and zero extension
    apply(4'd0, 16'd0, 0, 1, 16'hFFFF, 16'h0002, 2);
    apply(4'd1, 16'd0, 0, 1, 16'h0000, 16'h0001, 2);
    apply(4'd2, 16'd0, 0, 1, 16'h1234, 16'h0100, 2);
    // R1 immediate replaces opReg2
    apply(4'd0, 16'd7, 1, 1, 16'd5, 16'd100, 1);
    apply(4'd1, 16'd7, 0, 0, 16'd5, 16'd100, 1);
    // R4 division
    apply(4'd3, 16'd0, 0, 1, 16'd100, 16'd7, 4);
    apply(4'd3, 16'd0, 0, 1, 16'd100, 16'd0, 4);
    apply(4'd3, 16'd0, 1, 0, 16'h8000, 16'd5, 4);
    // R5 shifts and count masking
    apply(4'd4, 16'd0, 0, 1, 16'h8001, 16'd1, 5);
    apply(4'd5, 16'd0, 0, 1, 16'h8000, 16'd4, 5);
    apply(4'd6, 16'd0, 0, 1, 16'h8000, 16'd4, 5);
    apply(4'd6, 16'd0, 0, 1, 16'h4000, 16'd4, 5);
    apply(4'd4, 16'h0013, 1, 1, 16'h0001, 16'd0, 5);
    // R6 logic
    apply(4'd7, 16'd0, 0, 1, 16'hF0F0, 16'h3C3C, 6);
    apply(4'd8, 16'd0, 0, 1, 16'hF0F0, 16'h3C3C, 6);
    apply(4'd9, 16'h3C3C, 1, 1, 16'hF0F0, 16'd0, 6);
    // R3 hold when not updating
    apply(4'd0, 16'd0, 0, 0, 16'h1111, 16'h2222, 3);
    apply(4'd9, 16'd0, 0, 0, 16'hAAAA, 16'h5555, 3);
    // R7 select
    apply(4'd10, 16'hBEEF, 0, 1, 16'h8001, 16'h9000, 7);
    apply(4'd10, 16'hBEEF, 0, 0, 16'h8001, 16'h9000, 7);
    apply(4'd10, 16'hBEEF, 0, 0, 16'h0001, 16'h9000, 7);
    apply(4'd10, 16'hBEEF, 0, 0, 16'h0001, 16'h7000, 7);
    apply(4'd10, 16'hC000, 1, 0, 16'h0001, 16'h7000, 7);
    // R8 merge
    apply(4'd11, 16'h1357, 1, 1, 16'h2468, 16'h9999, 8);
    apply(4'd11, 16'h1357, 0, 1, 16'h2468, 16'h9999, 8);
    // R9 compares
    apply(4'd12, 16'd0, 0, 1, 16'h1234, 16'h1234, 9);
    apply(4'd12, 16'd0, 0, 1, 16'h1234, 16'h1235, 9);
    apply(4'd13, 16'd0, 0, 1, 16'hFFFF, 16'h0001, 9);
    apply(4'd13, 16'd0, 0, 1, 16'h0001, 16'h0001, 9);
    apply(4'd14, 16'd0, 0, 1, 16'h0001, 16'hFFFF, 9);
    apply(4'd14, 16'h7FFF, 1, 1, 16'h8000, 16'd0, 9);
    // R10 reserved code
    apply(4'd15, 16'hFFFF, 1, 1, 16'hFFFF, 16'hFFFF, 10);

    repeat (2) @(posedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule